// File: doc/BRIEF.md
# GPIO Alternate-Function Pin Multiplexer

This block sits between a set of 8-pin GPIO ports and the chip's peripherals. Every pin has an alternate-function enable bit and a 4-bit function code, each held per port in a register that is written through a simple write-only port. When a pin's enable bit is clear, the port's own data and direction registers drive the pin. When the bit is set, the function code selects the peripheral output signal, and that signal's output-enable, that drive the pin.

For the input direction, each peripheral input signal is driven from the pin that selects it. If pins on several ports select the same input, the lowest-numbered port supplies the value. If several pins select the same output, that output drives all of them. The per-pin digital enable, pull-up and pull-down settings are held in registers and passed on to the pads.

Out of reset, every pin is a quiet, undriven GPIO. The exception is one group of four protected pins, which come up in their debug function. Applying reset again always puts that group back into the debug function.

Top module: `gpio_altfn_mux`

## Requirements
- R1: Pin n of a port takes its function code from bits [4n+3:4n] of that port's function-select register. A nonzero code c on pin n selects peripheral signal index (c-1)*8+n. The same pin position and code therefore name the same signal on every port.
- R2: While a pin's enable bit is clear, pin_out equals that pin's data bit and pin_oe equals its direction bit, whatever its function code is.
- R3: While a pin's enable bit is set and its code is nonzero, pin_out and pin_oe follow per_out and per_oe of the selected signal, combinationally.
- R4: While a pin's enable bit is set and its code is 0, the pin is undriven: pin_oe is 0 and pin_out is 0.
- R5: When one peripheral output signal is selected on pins of several ports, every one of those pins carries it.
- R6: per_in of a signal equals pin_in of the lowest-numbered port whose matching pin has the enable bit set, the digital enable set and the matching code. Matching pins on higher-numbered ports are ignored.
- R7: per_in of a signal is 0 when no pin qualifies, including when a selecting pin has its digital enable clear.
- R8: A write with wr_en high updates register wr_reg of port wr_port at the next rising clock edge, not before. The register codes are: 0 data, 1 direction, 2 alternate-function enable, 3 function select (32 bits), 4 digital enable, 5 pull-up, 6 pull-down. A write with code 7 changes nothing.
- R9: Reset clears every register, except on port 2 pins 0 to 3. Those pins reset with enable 1, digital enable 1, pull-up 1, pull-down 0 and function code 1.
- R10: pad_den, pad_pu and pad_pd give each pin's digital-enable, pull-up and pull-down register bits. Global pin index is port*8+pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 2 | Port addressed by the write |
| wr_reg | input | 3 | Register code addressed by the write |
| wr_data | input | 32 | Write data (8-bit registers use bits [7:0]) |
| pin_in | input | 32 | Pin input levels, index port*8+pin |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| pad_den | output | 32 | Digital enable per pin |
| pad_pu | output | 32 | Pull-up enable per pin |
| pad_pd | output | 32 | Pull-down enable per pin |
| per_out | input | 120 | Peripheral output values, by signal index |
| per_oe | input | 120 | Peripheral output enables, by signal index |
| per_in | output | 120 | Peripheral input values, by signal index |

## Verification
The assertions assume that wr_port, wr_reg and wr_data are steady around the rising edge, and that pin_in, per_out and per_oe change only between edges. The bench drives every input on the falling edge and samples shortly after an edge, so both assumptions hold. The reset-image assertion also assumes that reset is asserted before the first clock edge. The bench holds rst_n low from time zero for several cycles to satisfy it.

// File: rtl/gafm_pkg.sv
package gafm_pkg;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_AFEN = 3'd2,
    REG_FSEL = 3'd3,
    REG_DEN  = 3'd4,
    REG_PU   = 3'd5,
    REG_PD   = 3'd6
  } reg_sel_e;

  // peripheral signal addressed by a nonzero code on a pin position
  function automatic int sig_index(input int code, input int pin, input int pins);
    return (code - 1) * pins + pin;
  endfunction

  // lowest set bit of a port-match vector (lowest port wins)
  function automatic logic [31:0] lowest_one(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/gafm_port_cfg.sv
module gafm_port_cfg
  import gafm_pkg::*;
#(
  parameter int PINS = 8,
  parameter int FSEL_W = 4,
  parameter bit IS_DBG = 1'b0,
  parameter logic [PINS-1:0] DBG_MASK = '0,
  parameter int DBG_CODE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_hit,
  input  logic [2:0]               wr_reg,
  input  logic [PINS*FSEL_W-1:0]   wr_data,
  output logic [PINS-1:0]          data_q,
  output logic [PINS-1:0]          dir_q,
  output logic [PINS-1:0]          afen_q,
  output logic [PINS*FSEL_W-1:0]   fsel_q,
  output logic [PINS-1:0]          den_q,
  output logic [PINS-1:0]          pu_q,
  output logic [PINS-1:0]          pd_q
);
  localparam int DW = PINS * FSEL_W;
  localparam logic [PINS-1:0] ON_RST = IS_DBG ? DBG_MASK : '0;

  function automatic logic [DW-1:0] fsel_image();
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < PINS; i++)
      if (ON_RST[i]) r[i*FSEL_W +: FSEL_W] = FSEL_W'(DBG_CODE);
    return r;
  endfunction

  localparam logic [DW-1:0] FSEL_RST = fsel_image();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      afen_q <= ON_RST;
      fsel_q <= FSEL_RST;
      den_q  <= ON_RST;
      pu_q   <= ON_RST;
      pd_q   <= '0;
    end else if (wr_hit) begin
      case (wr_reg)
        REG_DATA: data_q <= wr_data[PINS-1:0];
        REG_DIR:  dir_q  <= wr_data[PINS-1:0];
        REG_AFEN: afen_q <= wr_data[PINS-1:0];
        REG_FSEL: fsel_q <= wr_data;
        REG_DEN:  den_q  <= wr_data[PINS-1:0];
        REG_PU:   pu_q   <= wr_data[PINS-1:0];
        REG_PD:   pd_q   <= wr_data[PINS-1:0];
        default: ;
      endcase
    end
  end

  // set once any write reaches this port; until then the reset image must hold
  logic touched;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) touched <= 1'b0;
    else if (wr_hit) touched <= 1'b1;
  end

  assert_reset_image_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !touched |-> (afen_q == ON_RST && den_q == ON_RST && pu_q == ON_RST &&
                  pd_q == '0 && fsel_q == FSEL_RST && data_q == '0 && dir_q == '0));

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_reg == REG_FSEL) |=> (fsel_q == $past(wr_data)));

endmodule

// File: rtl/gafm_port_out.sv
module gafm_port_out
  import gafm_pkg::*;
#(
  parameter int PINS = 8,
  parameter int FSEL_W = 4
) (
  input  logic [PINS-1:0]          data_q,
  input  logic [PINS-1:0]          dir_q,
  input  logic [PINS-1:0]          afen_q,
  input  logic [PINS*FSEL_W-1:0]   fsel_q,
  input  logic [((1<<FSEL_W)-1)*PINS-1:0] per_out,
  input  logic [((1<<FSEL_W)-1)*PINS-1:0] per_oe,
  output logic [PINS-1:0]          pin_out,
  output logic [PINS-1:0]          pin_oe
);
  localparam int NSIG = ((1 << FSEL_W) - 1) * PINS;
  localparam int SIG_W = $clog2(NSIG);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [FSEL_W-1:0] code;
    logic [SIG_W-1:0]  idx;
    assign code = fsel_q[i*FSEL_W +: FSEL_W];
    assign idx  = SIG_W'(sig_index(int'(code), i, PINS));

    always_comb begin
      if (!afen_q[i]) begin
        pin_out[i] = data_q[i];
        pin_oe[i]  = dir_q[i];
      end else if (code == '0) begin
        pin_out[i] = 1'b0;
        pin_oe[i]  = 1'b0;
      end else begin
        pin_out[i] = per_out[idx];
        pin_oe[i]  = per_oe[idx];
      end
    end
  end

endmodule

// File: rtl/gafm_in_resolve.sv
module gafm_in_resolve
  import gafm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PINS = 8,
  parameter int FSEL_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PORTS*PINS-1:0]          pin_in,
  input  logic [NUM_PORTS*PINS-1:0]          afen_all,
  input  logic [NUM_PORTS*PINS-1:0]          den_all,
  input  logic [NUM_PORTS*PINS*FSEL_W-1:0]   fsel_all,
  output logic [((1<<FSEL_W)-1)*PINS-1:0]    per_in
);
  localparam int NSIG = ((1 << FSEL_W) - 1) * PINS;

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    localparam int PIN  = s % PINS;
    localparam int CODE = s / PINS + 1;

    logic [NUM_PORTS-1:0] match;
    logic [NUM_PORTS-1:0] win;
    logic [NUM_PORTS-1:0] lvl;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int G = p * PINS + PIN;
      assign match[p] = afen_all[G] & den_all[G] &
                        (fsel_all[G*FSEL_W +: FSEL_W] == FSEL_W'(CODE));
      assign lvl[p] = pin_in[G];
    end

    assign win       = NUM_PORTS'(lowest_one(32'(match)));
    assign per_in[s] = |(win & lvl);

    assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win) && ((match == '0) == (win == '0)));

    assert_unmapped_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (match == '0) |-> !per_in[s]);
  end

endmodule

// File: rtl/gpio_altfn_mux.sv
module gpio_altfn_mux
  import gafm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PINS = 8,
  parameter int FSEL_W = 4,
  parameter int DBG_PORT = 2,
  parameter logic [PINS-1:0] DBG_MASK = 'h0F,
  parameter int DBG_CODE = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [$clog2(NUM_PORTS)-1:0]          wr_port,
  input  logic [2:0]                            wr_reg,
  input  logic [PINS*FSEL_W-1:0]                wr_data,
  input  logic [NUM_PORTS*PINS-1:0]             pin_in,
  output logic [NUM_PORTS*PINS-1:0]             pin_out,
  output logic [NUM_PORTS*PINS-1:0]             pin_oe,
  output logic [NUM_PORTS*PINS-1:0]             pad_den,
  output logic [NUM_PORTS*PINS-1:0]             pad_pu,
  output logic [NUM_PORTS*PINS-1:0]             pad_pd,
  input  logic [((1<<FSEL_W)-1)*PINS-1:0]       per_out,
  input  logic [((1<<FSEL_W)-1)*PINS-1:0]       per_oe,
  output logic [((1<<FSEL_W)-1)*PINS-1:0]       per_in
);
  localparam int PW   = $clog2(NUM_PORTS);
  localparam int NPIN = NUM_PORTS * PINS;
  localparam int DW   = PINS * FSEL_W;

  logic [NPIN-1:0]        data_all, dir_all, afen_all;
  logic [NPIN*FSEL_W-1:0] fsel_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_hit;
    assign wr_hit = wr_en && (wr_port == PW'(p));

    gafm_port_cfg #(
      .PINS(PINS), .FSEL_W(FSEL_W), .IS_DBG(p == DBG_PORT),
      .DBG_MASK(DBG_MASK), .DBG_CODE(DBG_CODE)
    ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_reg(wr_reg), .wr_data(wr_data),
      .data_q(data_all[p*PINS +: PINS]), .dir_q(dir_all[p*PINS +: PINS]),
      .afen_q(afen_all[p*PINS +: PINS]), .fsel_q(fsel_all[p*DW +: DW]),
      .den_q(pad_den[p*PINS +: PINS]), .pu_q(pad_pu[p*PINS +: PINS]),
      .pd_q(pad_pd[p*PINS +: PINS])
    );

    gafm_port_out #(.PINS(PINS), .FSEL_W(FSEL_W)) u_out (
      .data_q(data_all[p*PINS +: PINS]), .dir_q(dir_all[p*PINS +: PINS]),
      .afen_q(afen_all[p*PINS +: PINS]), .fsel_q(fsel_all[p*DW +: DW]),
      .per_out(per_out), .per_oe(per_oe),
      .pin_out(pin_out[p*PINS +: PINS]), .pin_oe(pin_oe[p*PINS +: PINS])
    );
  end

  gafm_in_resolve #(.NUM_PORTS(NUM_PORTS), .PINS(PINS), .FSEL_W(FSEL_W)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .afen_all(afen_all),
    .den_all(pad_den), .fsel_all(fsel_all), .per_in(per_in)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_chk
    assert_gpio_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !afen_all[g] |-> (pin_out[g] == data_all[g] && pin_oe[g] == dir_all[g]));

    assert_code0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (afen_all[g] && fsel_all[g*FSEL_W +: FSEL_W] == '0) |-> (!pin_oe[g] && !pin_out[g]));
  end

endmodule

// File: tb/gpio_altfn_mux_test.sv
module gpio_altfn_mux_test;
  localparam int NSIG = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_port = '0;
  logic [2:0] wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pad_den, pad_pu, pad_pd;
  logic [NSIG-1:0] per_out = '0;
  logic [NSIG-1:0] per_oe = '0;
  logic [NSIG-1:0] per_in;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_altfn_mux uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_reg(wr_reg),
    .wr_data(wr_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pad_den(pad_den), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .per_out(per_out), .per_oe(per_oe), .per_in(per_in)
  );

  function automatic int sig(input int code, input int pin);
    return code * 8 - 8 + pin;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int port, input int rsel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = 2'(port); wr_reg = 3'(rsel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    chk("R9 pull-up image", 128'(pad_pu), 128'h000F0000);
    chk("R9 den image", 128'(pad_den), 128'h000F0000);
    chk("R9 pull-down image", 128'(pad_pd), 128'h0);
    chk("R9 quiet pins", 128'(pin_oe), 128'h0);
    per_oe[sig(1,0)] = 1'b1; per_oe[sig(1,1)] = 1'b1;
    per_oe[sig(1,2)] = 1'b1; per_oe[sig(1,3)] = 1'b1;
    per_out[sig(1,2)] = 1'b1;
    pin_in = 32'h000A0000;
    #1;
    chk("R9 R3 debug oe", 128'(pin_oe), 128'h000F0000);
    chk("R9 R3 debug out", 128'(pin_out), 128'h00040000);
    chk("R9 R6 debug inputs", 128'(per_in[3:0]), 128'hA);
    chk("R7 unmapped inputs low", 128'(per_in[NSIG-1:4]), 128'h0);
    per_oe = '0; per_out = '0; pin_in = '0;
  endtask

  task automatic t_gpio();
    @(negedge clk);
    wr_en = 1'b1; wr_port = 2'd1; wr_reg = 3'd0; wr_data = 32'hA5;
    #1;
    chk("R8 no effect before edge", 128'(pin_out[15:8]), 128'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R8 R2 data lands", 128'(pin_out[15:8]), 128'hA5);
    wr(1, 1, 32'h3C);
    chk("R2 direction", 128'(pin_oe[15:8]), 128'h3C);
    wr(1, 3, 32'h22222222);
    per_out = '1; per_oe = '1;
    #1;
    chk("R2 code ignored out", 128'(pin_out[15:8]), 128'hA5);
    chk("R2 code ignored oe", 128'(pin_oe[15:8]), 128'h3C);
    per_out = '0; per_oe = '0;
  endtask

  task automatic t_altout();
    wr(0, 3, 32'h02005000);
    wr(0, 2, 32'h48);
    wr(3, 3, 32'h00005000);
    wr(3, 2, 32'h08);
    per_out[sig(5,3)] = 1'b1; per_oe[sig(5,3)] = 1'b1;
    #1;
    chk("R5 R3 shared out", 128'({pin_out[27], pin_out[3]}), 128'h3);
    chk("R5 shared oe", 128'({pin_oe[27], pin_oe[3]}), 128'h3);
    per_out[sig(5,3)] = 1'b0;
    #1;
    chk("R5 shared out low", 128'({pin_out[27], pin_out[3]}), 128'h0);
    per_out[sig(2,6)] = 1'b1; per_oe[sig(2,6)] = 1'b1;
    #1;
    chk("R1 field position", 128'({pin_oe[6], pin_out[6]}), 128'h3);
    per_out = '0; per_oe = '0;
  endtask

  task automatic t_code0();
    wr(1, 3, 32'h0);
    wr(1, 2, 32'hFF);
    per_out = '1; per_oe = '1;
    #1;
    chk("R4 code zero oe", 128'(pin_oe[15:8]), 128'h0);
    chk("R4 code zero out", 128'(pin_out[15:8]), 128'h0);
    per_out = '0; per_oe = '0;
  endtask

  task automatic t_prio();
    wr(0, 3, 32'h02305000);
    wr(0, 2, 32'h68);
    wr(0, 4, 32'h20);
    wr(2, 3, 32'h00301111);
    wr(2, 2, 32'h2F);
    wr(2, 4, 32'h2F);
    pin_in = 32'h00000020;
    #1;
    chk("R6 low port wins high", 128'(per_in[sig(3,5)]), 128'h1);
    pin_in = 32'h00200000;
    #1;
    chk("R6 high port ignored", 128'(per_in[sig(3,5)]), 128'h0);
    wr(0, 2, 32'h48);
    chk("R6 fallback to next port", 128'(per_in[sig(3,5)]), 128'h1);
    wr(2, 4, 32'h00);
    chk("R7 den clear blocks input", 128'(per_in[sig(3,5)]), 128'h0);
    pin_in = '0;
  endtask

  task automatic t_badreg();
    wr(1, 7, 32'hFFFFFFFF);
    chk("R8 code 7 ignored oe", 128'(pin_oe[15:8]), 128'h0);
    chk("R8 code 7 ignored pads", 128'({pad_pu[15:8], pad_pd[15:8], pad_den[15:8]}), 128'h0);
    wr(1, 2, 32'h00);
    chk("R8 code 7 ignored data", 128'(pin_out[15:8]), 128'hA5);
  endtask

  task automatic t_pads();
    wr(3, 5, 32'h81);
    wr(3, 6, 32'h42);
    wr(3, 4, 32'h18);
    chk("R10 pull-up", 128'(pad_pu[31:24]), 128'h81);
    chk("R10 pull-down", 128'(pad_pd[31:24]), 128'h42);
    chk("R10 den", 128'(pad_den[31:24]), 128'h18);
  endtask

  task automatic t_reapply();
    wr(2, 2, 32'h00);
    wr(2, 5, 32'h00);
    do_reset();
    chk("R9 pull-up restored", 128'(pad_pu), 128'h000F0000);
    chk("R9 others cleared", 128'({pad_pd, pin_oe, pin_out}), 128'h0);
    per_oe[sig(1,1)] = 1'b1;
    #1;
    chk("R9 debug code restored", 128'(pin_oe), 128'h00020000);
    per_oe = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_gpio();
    t_altout();
    t_code0();
    t_prio();
    t_badreg();
    t_pads();
    t_reapply();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule